// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital sequencer of a 10-bit monitoring converter that works by successive approximation. It runs on a 40 MHz system clock. It divides that clock by 32 to make a slower conversion tick, and every state change happens on that tick. While a start request is held and the block is enabled, the next tick accepts a conversion. On that tick the block latches the 3-bit channel select, and the latched value steers the external 8-to-1 analog multiplexer.

The block then searches for the input level one bit at a time, starting with the most significant bit. For each bit it presents a trial code to the external DAC and reads one comparator bit back. After a settle tick and a latch tick, the 10-bit result appears and the busy flag drops. The whole sequence takes 13 ticks. The analog parts sit outside the block.

The result is a plain registered output with no back-pressure. It holds its value until the next conversion finishes, so a reader may sample it at any time while busy is low. Start, disable, busy and select are plain level signals. An active-high disable stops the divider, aborts any conversion in progress and blocks new requests.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, busy_o, result_o and dac_code_o are all 0.
- R2: The conversion tick fires once every 32 clocks while the block is enabled. A start request is accepted only on a tick, so busy_o rises at most 32 clocks after start_i goes high.
- R3: busy_o rises on the clock edge that accepts a request. It stays high for exactly 384 clocks (12 ticks) and then falls at the 13th tick of the conversion.
- R4: The search tests bits from MSB to LSB. The first trial code is 0x200. On each trial tick, the bit under test stays 1 if cmp_i=1 (input at or above the DAC level) and is cleared if cmp_i=0. The next lower bit is then set to 1.
- R5: result_o changes only on the clock edge where busy_o falls. At that edge it takes the final code, which equals the largest code the comparator accepts. At all other times result_o holds its value.
- R6: sel_i is latched on the accepting edge. mux_sel_o holds that value for the whole conversion, even if sel_i changes.
- R7: Driving off_i high aborts a conversion: busy_o is 0 one clock later, dac_code_o clears and result_o keeps its last value. While off_i is high, start_i has no effect.
- R8: If start_i is still high when a conversion completes, the next conversion is accepted exactly 32 clocks later. If start_i is low, busy_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Level request for a conversion |
| off_i | input | 1 | Active-high disable; stops and aborts the block |
| sel_i | input | 3 | Analog channel to convert |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code_o | output | 10 | Trial code driven to the DAC |
| mux_sel_o | output | 3 | Latched channel select for the multiplexer |
| busy_o | output | 1 | High while a conversion is running |
| result_o | output | 10 | Last completed conversion result |

## Verification
Two situations are the hardest to reach from the ports. The first is an abort in the middle of a search, which must leave the previous result in place. The bench gets there by completing a known conversion first, then starting another and raising off_i about 100 clocks in, while trial bits are still resolving. The second is the exact 32-clock gap between back-to-back conversions. The bench keeps start_i high across a completion and counts clocks from the fall of busy_o to its next rise. A behavioural comparator against a chosen target code closes the loop, and targets at 0, full scale and either side of mid-scale drive every bit both ways.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TRIAL  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_LATCH  = 2'd3
  } sar_state_e;
endpackage

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2
  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick); // R7
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_sar_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         off,
  input  logic         start,
  input  logic         cmp,
  output logic         accept,
  output logic [W-1:0] trial,
  output logic [W-1:0] result,
  output logic         busy
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  sar_state_e    st_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  trial_q, result_q, trial_nxt;
  logic          busy_q;

  assign accept = tick && !off && (st_q == ST_IDLE) && start;

  always_comb begin
    trial_nxt = trial_q;
    if (!cmp) trial_nxt[idx_q] = 1'b0;
    if (idx_q != '0) trial_nxt[idx_q - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      trial_q  <= '0;
      result_q <= '0;
      busy_q   <= 1'b0;
    end else if (off) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      trial_q <= '0;
      busy_q  <= 1'b0;
    end else if (tick) begin
      case (st_q)
        ST_IDLE: if (start) begin
          busy_q  <= 1'b1;
          trial_q <= MSB_ONLY;
          idx_q   <= TOP_IDX;
          st_q    <= ST_TRIAL;
        end
        ST_TRIAL: begin
          trial_q <= trial_nxt;
          if (idx_q == '0) st_q <= ST_SETTLE;
          else             idx_q <= idx_q - 1'b1;
        end
        ST_SETTLE: st_q <= ST_LATCH;
        ST_LATCH: begin
          result_q <= trial_q;
          busy_q   <= 1'b0;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign trial  = trial_q;
  assign result = result_q;
  assign busy   = busy_q;

  AST_OFF_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (!busy && trial == '0)); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || !tick || off) |=> $stable(result)); // R5
  AST_TRIAL_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !off) |=> $stable(trial)); // R4
  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && trial == MSB_ONLY)); // R3
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
  parameter int RES_W = 10,
  parameter int SEL_W = 3,
  parameter int DIV   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             off_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic [SEL_W-1:0] mux_sel_o,
  output logic             busy_o,
  output logic [RES_W-1:0] result_o
);
  logic tick, accept;
  logic [SEL_W-1:0] sel_q;

  adc_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (!off_i),
    .tick (tick)
  );

  adc_sar_core #(.W(RES_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .off   (off_i),
    .start (start_i),
    .cmp   (cmp_i),
    .accept(accept),
    .trial (dac_code_o),
    .result(result_o),
    .busy  (busy_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (accept) sel_q <= sel_i;
  end

  assign mux_sel_o = sel_q;

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mux_sel_o)); // R6
  AST_BUSY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !tick) |=> !busy_o); // R2
endmodule

// File: tb/test_adc_sar_seq.sv
module test_adc_sar_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       off_i = 1'b0;
  logic [2:0] sel_i = 3'd0;
  logic [9:0] target = 10'd0;
  logic       cmp_i;
  logic [9:0] dac_code_o, result_o;
  logic [2:0] mux_sel_o;
  logic       busy_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  assign cmp_i = (target >= dac_code_o);

  adc_sar_seq i_adc_sar_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .off_i(off_i),
    .sel_i(sel_i), .cmp_i(cmp_i), .dac_code_o(dac_code_o),
    .mux_sel_o(mux_sel_o), .busy_o(busy_o), .result_o(result_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_err = n_err + 1;
      $display("FAIL R3 watchdog expired: actual=%0d expected<%0d cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_err = n_err + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_busy(input bit lvl, output int k);
    k = 0;
    while (busy_o !== lvl && k < 1000) begin
      @(negedge clk);
      k = k + 1;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
    chk(result_o == 10'd0, "R1 result after reset", result_o, 0);
    chk(dac_code_o == 10'd0, "R1 dac code after reset", dac_code_o, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_convert(input logic [9:0] tgt, input logic [2:0] ch, input bit keep);
    int k;
    bit sel_ok = 1'b1;
    bit res_ok = 1'b1;
    logic [9:0] prev;
    logic [9:0] second;
    prev = result_o;
    target = tgt;
    sel_i = ch;
    start_i = 1'b1;
    wait_busy(1'b1, k);
    chk(k >= 1 && k <= 32, "R2 accept latency", k, 32);
    chk(dac_code_o == 10'h200, "R4 first trial", dac_code_o, 10'h200);
    chk(mux_sel_o == ch, "R6 latched select", mux_sel_o, ch);
    sel_i = ~ch;
    start_i = keep;
    second = tgt[9] ? 10'h300 : 10'h100;
    k = 0;
    while (busy_o && k < 1000) begin
      @(negedge clk);
      k = k + 1;
      if (k == 32)
        chk(dac_code_o == second, "R4 second trial", dac_code_o, second);
      if (busy_o && mux_sel_o != ch) sel_ok = 1'b0;
      if (busy_o && result_o != prev) res_ok = 1'b0;
    end
    chk(k == 384, "R3 busy width", k, 384);
    chk(sel_ok, "R6 select held", mux_sel_o, ch);
    chk(res_ok, "R5 result stable during conversion", result_o, prev);
    chk(result_o == tgt, "R5 final result", result_o, tgt);
  endtask

  task automatic t_idle();
    bit stayed = 1'b1;
    start_i = 1'b0;
    repeat (100) begin
      @(negedge clk);
      if (busy_o) stayed = 1'b0;
    end
    chk(stayed, "R8 no start stays idle", busy_o, 0);
  endtask

  task automatic t_back_to_back();
    int k;
    t_convert(10'h155, 3'd5, 1'b1);
    k = 0;
    while (!busy_o && k < 1000) begin
      @(negedge clk);
      k = k + 1;
    end
    chk(k == 32, "R8 back-to-back gap", k, 32);
    start_i = 1'b0;
    wait_busy(1'b0, k);
    chk(result_o == 10'h155, "R8 second result", result_o, 10'h155);
  endtask

  task automatic t_abort();
    int k;
    bit stayed = 1'b1;
    logic [9:0] prev;
    prev = result_o;
    target = 10'h0F0;
    start_i = 1'b1;
    wait_busy(1'b1, k);
    repeat (100) @(negedge clk);
    off_i = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0, "R7 abort drops busy", busy_o, 0);
    chk(dac_code_o == 10'd0, "R7 abort clears dac code", dac_code_o, 0);
    chk(result_o == prev, "R7 abort keeps result", result_o, prev);
    repeat (200) begin
      @(negedge clk);
      if (busy_o) stayed = 1'b0;
    end
    chk(stayed, "R7 start ignored while off", busy_o, 0);
    chk(result_o == prev, "R7 result kept while off", result_o, prev);
    start_i = 1'b0;
    off_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    t_idle();
    t_convert(10'h000, 3'd1, 1'b0);
    t_convert(10'h3FF, 3'd6, 1'b0);
    t_convert(10'h200, 3'd2, 1'b0);
    t_convert(10'h1FF, 3'd7, 1'b0);
    t_convert(10'h2AA, 3'd3, 1'b0);
    t_abort();
    t_back_to_back();
    t_idle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule